// File: doc/BRIEF.md
# I2C Write Master for 10-Bit Slave Addresses

This block is an I2C bus master that writes to slaves with 10-bit addresses. A host hands it one byte at a time through a single holding register. The host also sets two control bits, one to begin a transfer and one to end it. An interrupt output tells the host when the holding register has room for the next byte.

The host writes the first header byte itself. That byte is `11110`, then the top two address bits, then a 0 for write. The host then requests START. The second byte carries the low eight address bits, and the data bytes follow it. The master drives SCL and SDA open-drain, shifts each byte out MSB first and checks the acknowledge on the ninth clock. It waits while a slave stretches the clock. A refusal ends the transfer with STOP.

SCL timing comes from a run-time divider input `div_i`. Each clock half lasts `div_i` system cycles. The high half is counted from the moment SCL is seen high on the bus.

Top module: `i2c10_wr_master`

## Requirements
- R1: After reset, SCL and SDA are released, the holding register is empty, and busy, the START and STOP control bits and the NACK flag are all 0.
- R2: A START condition (SDA falling while SCL is high) is produced only when the START control bit is set and the holding register is full. Setting START while the register is empty leaves the bus idle until a byte is written.
- R3: Bytes leave the holding register in write order and go onto SDA MSB first, sampled on the rising edge of SCL. SDA changes only while SCL is low, except during START and STOP. The first byte is sent exactly as written, so the `11110 a9 a8 0` header goes out unchanged, followed by the low address byte.
- R4: On the ninth clock of each byte the master releases SDA and samples it at the end of the high half. Low means acknowledge.
- R5: `empty_o` goes to 1 when a byte is moved from the holding register into the shifter, which happens at START or after an acknowledge. `irq_o` equals `irq_en_i` AND `empty_o`.
- R6: A not-acknowledge makes the master send STOP without sending further bytes. It also sets the sticky `nack_o` flag, which stays set until the host next sets START.
- R7: While a slave holds SCL low, the master stays in the high half of the current clock and does not count it. Counting begins once SCL is seen high.
- R8: After an acknowledged byte, if the holding register is empty and the STOP control bit is set, the master sends STOP: SDA rises while SCL is high.
- R9: After an acknowledged byte, if the holding register is empty and STOP is not set, the master holds SCL low until a byte is written or STOP is set.
- R10: The START and STOP control bits are cleared when the STOP condition completes on the bus.
- R11: Each SCL low half driven inside a byte lasts exactly `div_i` cycles. Each high half lasts at least `div_i` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | DIVW | SCL half-period in clock cycles (minimum 3) |
| wr_i | input | 1 | Write strobe for the holding register |
| wdata_i | input | 8 | Byte to load into the holding register |
| start_set_i | input | 1 | Sets the START control bit and clears the NACK flag |
| stop_set_i | input | 1 | Sets the STOP control bit |
| irq_en_i | input | 1 | Enables the empty-register interrupt |
| irq_o | output | 1 | Interrupt: holding register empty and interrupt enabled |
| empty_o | output | 1 | Holding register is empty |
| start_o | output | 1 | START control bit |
| stop_o | output | 1 | STOP control bit |
| nack_o | output | 1 | Sticky not-acknowledge flag |
| busy_o | output | 1 | A transfer is in progress on the bus |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_oe_o | output | 1 | When 1, pull SCL low |
| sda_oe_o | output | 1 | When 1, pull SDA low |

## Verification
The assertions rest on three assumptions about the block's inputs:
- `div_i` is at least 3 and does not change during a transfer.
- The host writes a byte only while the holding register is empty.
- The bus lines are wired-AND of this master and one slave, with no second master.

The bench keeps within these limits. It fixes the divider at 8 and writes only after seeing `empty_o`. Its slave model changes SDA only while SCL is low, releases its acknowledge after the ninth clock falls, and stretches SCL only in the low half of a clock.

// File: rtl/i2c10_wr_master.sv
module i2c10_wr_master #(
  parameter int DIVW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div_i,
  input  logic            wr_i,
  input  logic [7:0]      wdata_i,
  input  logic            start_set_i,
  input  logic            stop_set_i,
  input  logic            irq_en_i,
  output logic            irq_o,
  output logic            empty_o,
  output logic            start_o,
  output logic            stop_o,
  output logic            nack_o,
  output logic            busy_o,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            scl_oe_o,
  output logic            sda_oe_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_LOW, S_HIGH, S_HOLD, S_PLOW, S_PHIGH, S_PEND
  } st_t;

  st_t            st;
  logic [DIVW-1:0] cnt;
  logic [7:0]     hold_q, sh_q;
  logic [3:0]     bitn;
  logic           full_q, start_q, stop_q, nack_q, sda_oe_q;
  logic [1:0]     scl_ff, sda_ff;
  logic           sda_want, load;

  wire scl_s     = scl_ff[1];
  wire sda_s     = sda_ff[1];
  wire half_done = (cnt == div_i - 1'b1);
  wire ack_bit   = (bitn == 4'd8);
  wire hi_done   = scl_s && half_done;

  always_comb begin
    case (st)
      S_START, S_HOLD, S_PLOW, S_PHIGH: sda_want = 1'b1;
      S_LOW, S_HIGH:                    sda_want = !ack_bit && !sh_q[7];
      default:                          sda_want = 1'b0;
    endcase
  end

  assign load = (st == S_START && half_done) ||
                (st == S_HIGH && hi_done && ack_bit && !sda_s && full_q) ||
                (st == S_HOLD && full_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      hold_q   <= '0;
      sh_q     <= '0;
      bitn     <= '0;
      full_q   <= 1'b0;
      start_q  <= 1'b0;
      stop_q   <= 1'b0;
      nack_q   <= 1'b0;
      sda_oe_q <= 1'b0;
      scl_ff   <= 2'b11;
      sda_ff   <= 2'b11;
    end else begin
      scl_ff   <= {scl_ff[0], scl_i};
      sda_ff   <= {sda_ff[0], sda_i};
      sda_oe_q <= sda_want;
      if (wr_i) begin
        hold_q <= wdata_i;
        full_q <= 1'b1;
      end else if (load) begin
        full_q <= 1'b0;
      end
      if (load) begin
        sh_q <= hold_q;
        bitn <= '0;
      end
      if (start_set_i) begin
        start_q <= 1'b1;
        nack_q  <= 1'b0;
      end
      if (stop_set_i) stop_q <= 1'b1;
      cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (start_q && full_q) st <= S_START;
        end
        S_START, S_LOW, S_PLOW: if (half_done) begin
          cnt <= '0;
          st  <= (st == S_PLOW) ? S_PHIGH : S_HIGH;
          if (st == S_START) st <= S_LOW;
        end
        S_HIGH: begin
          if (!scl_s) cnt <= '0;
          else if (half_done) begin
            cnt <= '0;
            if (!ack_bit) begin
              sh_q <= {sh_q[6:0], 1'b0};
              bitn <= bitn + 4'd1;
              st   <= S_LOW;
            end else if (sda_s) begin
              nack_q <= 1'b1;
              st     <= S_PLOW;
            end else if (full_q) st <= S_LOW;
            else if (stop_q)     st <= S_PLOW;
            else                 st <= S_HOLD;
          end
        end
        S_HOLD: begin
          cnt <= '0;
          if (full_q)      st <= S_LOW;
          else if (stop_q) st <= S_PLOW;
        end
        S_PHIGH: begin
          if (!scl_s) cnt <= '0;
          else if (half_done) begin
            cnt <= '0;
            st  <= S_PEND;
          end
        end
        S_PEND: if (half_done) begin
          cnt     <= '0;
          st      <= S_IDLE;
          start_q <= 1'b0;
          stop_q  <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign scl_oe_o = (st == S_LOW) || (st == S_HOLD) || (st == S_PLOW);
  assign sda_oe_o = sda_oe_q;
  assign busy_o   = (st != S_IDLE);
  assign empty_o  = !full_q;
  assign irq_o    = irq_en_i && !full_q;
  assign start_o  = start_q;
  assign stop_o   = stop_q;
  assign nack_o   = nack_q;

  p_start_needs_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(start_o) && !$past(empty_o)));

  p_sda_steady_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIGH && $past(st) == S_HIGH) |-> $stable(sda_oe_o));

  p_nack_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_o && !start_set_i) |=> nack_o);

  p_stretch_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIGH && !scl_s) |=> (st == S_HIGH));

  p_ctrl_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_PEND && st == S_IDLE) |-> (!start_o && !stop_o));

endmodule

// File: tb/i2c10_wr_master_test.sv
module i2c10_wr_master_test;
  localparam int DIV = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic [11:0] div_i = 12'(DIV);
  logic wr_i = 0, start_set_i = 0, stop_set_i = 0, irq_en_i = 1;
  logic [7:0] wdata_i = 0;
  logic irq_o, empty_o, start_o, stop_o, nack_o, busy_o, scl_oe_o, sda_oe_o;
  logic sl_ack = 0, sl_hold = 0;

  wire scl_line = !(scl_oe_o || sl_hold);
  wire sda_line = !(sda_oe_o || sl_ack);

  always #10 clk = !clk;

  i2c10_wr_master uut (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .start_set_i(start_set_i), .stop_set_i(stop_set_i), .irq_en_i(irq_en_i),
    .irq_o(irq_o), .empty_o(empty_o), .start_o(start_o), .stop_o(stop_o),
    .nack_o(nack_o), .busy_o(busy_o), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave model
  logic [7:0] bytes [0:15];
  logic [7:0] sh = 0;
  int nbytes = 0, bitc = 0, starts = 0, stops = 0, nack_at = -1;
  int stretch_at = -1, stretch_len = 0, hcnt = 0;
  int cyc = 0, t_fall = -1, t_rise = -1, min_low = 1000, min_high = 1000;
  bit in_frame = 0, scl_p = 1, sda_p = 1;

  always @(posedge clk) begin
    cyc++;
    if (scl_line && !scl_p) begin
      if (in_frame && t_fall >= 0 && (cyc - t_fall) < min_low) min_low = cyc - t_fall;
      t_rise = cyc;
      if (bitc < 8) begin
        sh = {sh[6:0], sda_line};
        bitc++;
      end
    end
    if (!scl_line && scl_p) begin
      if (in_frame && t_rise >= 0 && (cyc - t_rise) < min_high) min_high = cyc - t_rise;
      t_fall = cyc;
      if (bitc == 8) begin
        bytes[nbytes[3:0]] = sh;
        sl_ack <= (nbytes != nack_at);
        nbytes++;
        bitc = 9;
      end else if (bitc == 9) begin
        sl_ack <= 1'b0;
        bitc = 0;
        if (nbytes - 1 == stretch_at) begin
          sl_hold <= 1'b1;
          hcnt = stretch_len;
        end
      end
    end
    if (hcnt > 0) begin
      hcnt--;
      if (hcnt == 0) sl_hold <= 1'b0;
    end
    if (scl_line && scl_p && sda_p && !sda_line) begin
      starts++; bitc = 0; in_frame = 1; t_fall = -1; t_rise = -1;
    end
    if (scl_line && scl_p && !sda_p && sda_line) begin
      stops++; in_frame = 0;
    end
    scl_p = scl_line;
    sda_p = sda_line;
  end

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_i = 1; wdata_i = b;
    @(negedge clk); wr_i = 0;
  endtask
  task automatic go_start();
    @(negedge clk); start_set_i = 1;
    @(negedge clk); start_set_i = 0;
  endtask
  task automatic go_stop();
    @(negedge clk); stop_set_i = 1;
    @(negedge clk); stop_set_i = 0;
  endtask
  task automatic wait_empty();
    @(negedge clk);
    while (!empty_o) @(negedge clk);
  endtask
  task automatic wait_idle();
    @(negedge clk);
    while (busy_o || start_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] hdr(input logic [9:0] a);
    return {5'b11110, a[9:8], 1'b0};
  endfunction

  task automatic run_txn(input logic [9:0] a, input int n, input logic [23:0] d);
    int s0;
    s0 = stops;
    nbytes = 0;
    wr(hdr(a));
    go_start();
    wait_empty();
    wr(a[7:0]);
    for (int i = 0; i < n; i++) begin
      wait_empty();
      wr(d[23-8*i -: 8]);
    end
    wait_empty();
    go_stop();
    wait_idle();
    chk(nbytes == n + 2, "R3 byte count", nbytes, n + 2);
    chk(bytes[0] == hdr(a), "R3 header byte", bytes[0], hdr(a));
    chk(bytes[1] == a[7:0], "R3 low address byte", bytes[1], a[7:0]);
    for (int i = 0; i < n; i++)
      chk(bytes[i+2] == d[23-8*i -: 8], "R3 data byte", bytes[i+2], d[23-8*i -: 8]);
    chk(stops == s0 + 1, "R8 stop sent", stops, s0 + 1);
    chk(!start_o && !stop_o, "R10 control bits cleared", {start_o, stop_o}, 0);
    chk(!nack_o, "R4 acknowledged", nack_o, 0);
  endtask

  // {addr10, count2, d0, d1, d2}
  localparam logic [35:0] VEC [4] = '{
    {10'h3FF, 2'd1, 8'hA5, 8'h00, 8'h00},
    {10'h000, 2'd3, 8'h00, 8'hFF, 8'h5A},
    {10'h2C3, 2'd2, 8'h81, 8'h7E, 8'h00},
    {10'h155, 2'd0, 8'h00, 8'h00, 8'h00}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s0, st0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!scl_oe_o && !sda_oe_o, "R1 lines released", {scl_oe_o, sda_oe_o}, 0);
    chk(empty_o && !busy_o, "R1 empty and idle", {empty_o, busy_o}, 2);
    chk(!start_o && !stop_o && !nack_o, "R1 flags clear", {start_o, stop_o, nack_o}, 0);
    chk(irq_o == 1'b1, "R5 irq when empty and enabled", irq_o, 1);
    irq_en_i = 0; @(negedge clk);
    chk(irq_o == 1'b0, "R5 irq masked", irq_o, 0);
    irq_en_i = 1;

    for (int v = 0; v < 4; v++)
      run_txn(VEC[v][35:26], int'(VEC[v][25:24]), VEC[v][23:0]);

    // R2 START without data stays idle
    nbytes = 0; st0 = starts; s0 = stops;
    go_start();
    repeat (60) @(negedge clk);
    chk(!busy_o && starts == st0, "R2 no start while empty", starts - st0, 0);
    chk(!sda_oe_o && !scl_oe_o, "R2 bus idle", {scl_oe_o, sda_oe_o}, 0);
    wr(hdr(10'h1E7));
    wait_empty();
    chk(starts == st0 + 1, "R2 start after byte written", starts - st0, 1);
    chk(empty_o && irq_o, "R5 empty after load", {empty_o, irq_o}, 3);
    wr(8'hE7);
    wait_empty();
    // R9 hold SCL low with no data and no stop
    repeat (300) @(negedge clk);
    chk(scl_oe_o && !scl_line && busy_o, "R9 scl held low", scl_oe_o, 1);
    chk(stops == s0 && nbytes == 2, "R9 no stop no extra byte", nbytes, 2);
    go_stop();
    wait_idle();
    chk(stops == s0 + 1, "R8 stop from hold", stops - s0, 1);
    chk(bytes[1] == 8'hE7, "R3 low address after hold", bytes[1], 8'hE7);

    // R6 NACK on second address byte
    nbytes = 0; nack_at = 1; s0 = stops;
    wr(hdr(10'h2AA));
    go_start();
    wait_empty();
    wr(8'hAA);
    wait_empty();
    wr(8'h33);
    wait_idle();
    chk(nack_o == 1'b1, "R6 nack flag set", nack_o, 1);
    chk(nbytes == 2, "R6 no byte after nack", nbytes, 2);
    chk(stops == s0 + 1, "R6 stop after nack", stops - s0, 1);
    chk(!start_o, "R10 start cleared after nack stop", start_o, 0);
    repeat (50) @(negedge clk);
    chk(nack_o == 1'b1, "R6 nack sticky", nack_o, 1);
    nack_at = -1;
    run_txn(10'h2AA, 1, {8'h3C, 16'h0});
    chk(nack_o == 1'b0, "R6 nack cleared by start", nack_o, 0);

    // R7 clock stretching
    nbytes = 0; stretch_at = 1; stretch_len = 120;
    wr(hdr(10'h0F0));
    go_start();
    wait_empty();
    wr(8'hF0);
    wait_empty();
    wr(8'hC6);
    @(negedge clk);
    while (!sl_hold) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(!scl_oe_o && !scl_line && busy_o, "R7 master waits released", scl_oe_o, 0);
    chk(nbytes == 2, "R7 no progress while stretched", nbytes, 2);
    wait_empty();
    go_stop();
    wait_idle();
    stretch_at = -1;
    chk(nbytes == 3 && bytes[2] == 8'hC6, "R7 byte after stretch", bytes[2], 8'hC6);

    // R11 clock halves
    chk(min_low == DIV, "R11 low half", min_low, DIV);
    chk(min_high >= DIV, "R11 high half", min_high, DIV);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule